// File: doc/BRIEF.md
# Two-Paddle Ball Game Engine

This block holds the complete game state for a two-player paddle-and-ball game and turns it into pixel colours. Once per video frame, on the frame-end pulse, it reads four button bits, moves the two paddles within the screen, moves the ball by its current speed, and resolves bounces off the roof, the floor and the paddles. A ball that reaches a goal line with no paddle there restarts the game from a centred position.

Every clock the renderer takes the pixel coordinate being scanned and reports, one cycle later, whether that pixel lies in the ball, the left paddle, the right paddle or the background, together with the matching 12-bit colour. The pixel path follows the raster timing and has no back-pressure: one coordinate enters and one result leaves every cycle, so it carries neither valid nor ready. The state registers are also brought out as ports so that the game can be watched directly.

Top module: `pong_engine`

## Requirements
- R1: Buttons map as bit 0 right paddle up, bit 1 right paddle down, bit 2 left paddle up, bit 3 left paddle down; a paddle with both or neither of its buttons pressed does not move.
- R2: A paddle moves up (y decreases) by PAD_STEP in a frame update only when its up button alone is pressed and its y is at least PAD_STEP.
- R3: A paddle moves down by PAD_STEP only when its down button alone is pressed and y + PAD_STEP is at most FRAME_H - PAD_H.
- R4: A ball moving up with y = 0 turns to move down and keeps its y in that update; an upward move otherwise subtracts the speed and stops at 0.
- R5: A ball moving down with y = FRAME_H - BALL_SZ turns to move up and keeps its y; a downward move otherwise adds the speed and stops at FRAME_H - BALL_SZ.
- R6: A ball standing on a goal line (x = PAD_L_X + PAD_W moving left, or x = PAD_R_X - BALL_SZ moving right) whose rows overlap that side's paddle reverses its horizontal direction, keeps x, and gains one speed step, saturating at SPD_MAX.
- R7: A ball on a goal line with no row overlap with that side's paddle returns all state to the centred start: ball at ((FRAME_W-BALL_SZ)/2, (FRAME_H-BALL_SZ)/2) moving right and down at SPD_INIT, both paddles at (FRAME_H-PAD_H)/2.
- R8: Away from the goal lines the ball moves horizontally by its speed and stops exactly on the goal line it approaches.
- R9: Reset gives the centred start with a pending restart; the first frame-end clears the restart without moving anything; state changes on no clock edge where frame_end is low. Collisions use the positions held before the update.
- R10: pix_class is registered one cycle after pix_x/pix_y and uses the state held at that edge: 1 ball, 2 left paddle, 3 right paddle, 0 background, in that priority; the left paddle spans x in [PAD_L_X, PAD_L_X+PAD_W), the right one [PAD_R_X, PAD_R_X+PAD_W).
- R11: pix_rgb is BALL_RGB, LPAD_RGB, RPAD_RGB or BG_RGB to match pix_class in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| buttons | input | 4 | Paddle buttons (R1 mapping) |
| frame_end | input | 1 | One-cycle pulse that advances the game |
| pix_x | input | CW | Column of the pixel being scanned |
| pix_y | input | CW | Row of the pixel being scanned |
| pix_class | output | 2 | Object under the previous cycle's pixel |
| pix_rgb | output | 12 | Colour of that pixel |
| ball_x | output | CW | Ball left edge |
| ball_y | output | CW | Ball top edge |
| ball_speed | output | SW | Ball speed in pixels per frame |
| paddle_l_y | output | CW | Left paddle top edge |
| paddle_r_y | output | CW | Right paddle top edge |

## Verification
State results appear on the rising edge that samples frame_end high and are settled by the following falling edge; pixel results appear on the rising edge after the coordinate is presented. The bench drives inputs on falling edges, advances a behavioural model on each rising edge from those same inputs (rendering with the model state before it applies the frame update), and compares every output on the next falling edge, so each result is checked exactly one edge after its cause and on every cycle in between.

// File: rtl/pong_pkg.sv
package pong_pkg;
  typedef enum logic [1:0] {
    PIX_BG   = 2'd0,
    PIX_BALL = 2'd1,
    PIX_LPAD = 2'd2,
    PIX_RPAD = 2'd3
  } pix_class_e;
endpackage

// File: rtl/paddle_stepper.sv
module paddle_stepper #(
  parameter int CW       = 12,
  parameter int FRAME_H  = 480,
  parameter int PAD_H    = 64,
  parameter int PAD_STEP = 4
) (
  input  logic [CW-1:0] y_cur,
  input  logic          go_up,
  input  logic          go_dn,
  output logic [CW-1:0] y_nxt
);
  localparam logic [CW-1:0] STEP_C  = CW'(PAD_STEP);
  localparam logic [CW:0]   LIMIT_C = (CW+1)'(FRAME_H - PAD_H);

  always_comb begin
    y_nxt = y_cur;
    if (go_up && !go_dn) begin
      if (y_cur >= STEP_C) y_nxt = y_cur - STEP_C;
    end else if (go_dn && !go_up) begin
      if (({1'b0, y_cur} + {1'b0, STEP_C}) <= LIMIT_C) y_nxt = y_cur + STEP_C;
    end
  end
endmodule

// File: rtl/ball_stepper.sv
module ball_stepper #(
  parameter int CW      = 12,
  parameter int SW      = 4,
  parameter int FRAME_H = 480,
  parameter int BALL_SZ = 8,
  parameter int PAD_H   = 64,
  parameter int GOAL_L  = 24,
  parameter int GOAL_R  = 608,
  parameter int SPD_MAX = 8
) (
  input  logic [CW-1:0] bx,
  input  logic [CW-1:0] by,
  input  logic          dir_r,
  input  logic          dir_d,
  input  logic [SW-1:0] spd,
  input  logic [CW-1:0] ly,
  input  logic [CW-1:0] ry,
  output logic [CW-1:0] bx_nxt,
  output logic [CW-1:0] by_nxt,
  output logic          dir_r_nxt,
  output logic          dir_d_nxt,
  output logic [SW-1:0] spd_nxt,
  output logic          goal
);
  localparam logic [CW-1:0] BOT_C = CW'(FRAME_H - BALL_SZ);
  localparam logic [CW-1:0] GL_C  = CW'(GOAL_L);
  localparam logic [CW-1:0] GR_C  = CW'(GOAL_R);
  localparam logic [CW:0]   PH1   = (CW+1)'(PAD_H);
  localparam logic [CW:0]   BS1   = (CW+1)'(BALL_SZ);
  localparam logic [SW-1:0] SMAX  = SW'(SPD_MAX);

  logic [CW:0]   sp1;
  logic [SW-1:0] spd_up;
  logic          hit_l, hit_r;

  function automatic logic rows_meet(input logic [CW-1:0] b, input logic [CW-1:0] p);
    return ({1'b0, b} < ({1'b0, p} + PH1)) && (({1'b0, b} + BS1) > {1'b0, p});
  endfunction

  assign sp1    = {{(CW+1-SW){1'b0}}, spd};
  assign spd_up = (spd >= SMAX) ? SMAX : spd + 1'b1;
  assign hit_l  = rows_meet(by, ly);
  assign hit_r  = rows_meet(by, ry);

  // vertical motion and wall bounces
  always_comb begin
    by_nxt    = by;
    dir_d_nxt = dir_d;
    if (!dir_d && by == '0)        dir_d_nxt = 1'b1;
    else if (dir_d && by == BOT_C) dir_d_nxt = 1'b0;
    else if (dir_d)
      by_nxt = (({1'b0, by} + sp1) >= {1'b0, BOT_C}) ? BOT_C : by + sp1[CW-1:0];
    else
      by_nxt = ({1'b0, by} >= sp1) ? by - sp1[CW-1:0] : '0;
  end

  // horizontal motion, paddle bounces and goals
  always_comb begin
    bx_nxt    = bx;
    dir_r_nxt = dir_r;
    spd_nxt   = spd;
    goal      = 1'b0;
    if (!dir_r && bx == GL_C) begin
      if (hit_l) begin dir_r_nxt = 1'b1; spd_nxt = spd_up; end
      else goal = 1'b1;
    end else if (dir_r && bx == GR_C) begin
      if (hit_r) begin dir_r_nxt = 1'b0; spd_nxt = spd_up; end
      else goal = 1'b1;
    end else if (dir_r)
      bx_nxt = (({1'b0, bx} + sp1) >= {1'b0, GR_C}) ? GR_C : bx + sp1[CW-1:0];
    else
      bx_nxt = ({1'b0, bx} <= ({1'b0, GL_C} + sp1)) ? GL_C : bx - sp1[CW-1:0];
  end
endmodule

// File: rtl/pixel_render.sv
module pixel_render
  import pong_pkg::*;
#(
  parameter int          CW       = 12,
  parameter int          BALL_SZ  = 8,
  parameter int          PAD_W    = 8,
  parameter int          PAD_H    = 64,
  parameter int          PAD_L_X  = 16,
  parameter int          PAD_R_X  = 616,
  parameter logic [11:0] BALL_RGB = 12'hFFF,
  parameter logic [11:0] LPAD_RGB = 12'h0F0,
  parameter logic [11:0] RPAD_RGB = 12'hF80,
  parameter logic [11:0] BG_RGB   = 12'h004
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] px,
  input  logic [CW-1:0] py,
  input  logic [CW-1:0] bx,
  input  logic [CW-1:0] by,
  input  logic [CW-1:0] ly,
  input  logic [CW-1:0] ry,
  output pix_class_e    cls_q,
  output logic [11:0]   rgb_q
);
  localparam logic [CW:0] BS1 = (CW+1)'(BALL_SZ);
  localparam logic [CW:0] PW1 = (CW+1)'(PAD_W);
  localparam logic [CW:0] PH1 = (CW+1)'(PAD_H);
  localparam logic [CW:0] LX1 = (CW+1)'(PAD_L_X);
  localparam logic [CW:0] RX1 = (CW+1)'(PAD_R_X);

  function automatic logic span(input logic [CW:0] p, input logic [CW:0] o, input logic [CW:0] w);
    return (p >= o) && (p < o + w);
  endfunction

  logic [CW:0] px1, py1;
  logic        in_ball, in_l, in_r;
  pix_class_e  cls_d;
  logic [11:0] rgb_d;

  assign px1     = {1'b0, px};
  assign py1     = {1'b0, py};
  assign in_ball = span(px1, {1'b0, bx}, BS1) && span(py1, {1'b0, by}, BS1);
  assign in_l    = span(px1, LX1, PW1) && span(py1, {1'b0, ly}, PH1);
  assign in_r    = span(px1, RX1, PW1) && span(py1, {1'b0, ry}, PH1);

  always_comb begin
    if (in_ball)   begin cls_d = PIX_BALL; rgb_d = BALL_RGB; end
    else if (in_l) begin cls_d = PIX_LPAD; rgb_d = LPAD_RGB; end
    else if (in_r) begin cls_d = PIX_RPAD; rgb_d = RPAD_RGB; end
    else           begin cls_d = PIX_BG;   rgb_d = BG_RGB;   end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_q <= PIX_BG;
      rgb_q <= BG_RGB;
    end else begin
      cls_q <= cls_d;
      rgb_q <= rgb_d;
    end
  end
endmodule

// File: rtl/pong_engine.sv
module pong_engine
  import pong_pkg::*;
#(
  parameter int          CW       = 12,
  parameter int          SW       = 4,
  parameter int          FRAME_W  = 640,
  parameter int          FRAME_H  = 480,
  parameter int          BALL_SZ  = 8,
  parameter int          PAD_W    = 8,
  parameter int          PAD_H    = 64,
  parameter int          PAD_STEP = 4,
  parameter int          PAD_L_X  = 16,
  parameter int          PAD_R_X  = 616,
  parameter int          SPD_INIT = 1,
  parameter int          SPD_MAX  = 8,
  parameter logic [11:0] BALL_RGB = 12'hFFF,
  parameter logic [11:0] LPAD_RGB = 12'h0F0,
  parameter logic [11:0] RPAD_RGB = 12'hF80,
  parameter logic [11:0] BG_RGB   = 12'h004
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    buttons,
  input  logic          frame_end,
  input  logic [CW-1:0] pix_x,
  input  logic [CW-1:0] pix_y,
  output logic [1:0]    pix_class,
  output logic [11:0]   pix_rgb,
  output logic [CW-1:0] ball_x,
  output logic [CW-1:0] ball_y,
  output logic [SW-1:0] ball_speed,
  output logic [CW-1:0] paddle_l_y,
  output logic [CW-1:0] paddle_r_y
);
  localparam int GOAL_L = PAD_L_X + PAD_W;
  localparam int GOAL_R = PAD_R_X - BALL_SZ;
  localparam logic [CW-1:0] BX0  = CW'((FRAME_W - BALL_SZ) / 2);
  localparam logic [CW-1:0] BY0  = CW'((FRAME_H - BALL_SZ) / 2);
  localparam logic [CW-1:0] PY0  = CW'((FRAME_H - PAD_H) / 2);
  localparam logic [SW-1:0] SPD0 = SW'(SPD_INIT);

  logic [CW-1:0] bx_q, by_q, ly_q, ry_q;
  logic          dr_q, dd_q, restart_q;
  logic [SW-1:0] sp_q;

  logic [CW-1:0] bx_n, by_n;
  logic          dr_n, dd_n, goal;
  logic [SW-1:0] sp_n;
  logic [CW-1:0] pad_cur [2];
  logic [CW-1:0] pad_nxt [2];
  pix_class_e    cls;

  assign pad_cur[0] = ry_q;
  assign pad_cur[1] = ly_q;

  // index 0: right paddle on bits 1:0, index 1: left paddle on bits 3:2
  for (genvar g = 0; g < 2; g++) begin : g_pad
    paddle_stepper #(
      .CW(CW), .FRAME_H(FRAME_H), .PAD_H(PAD_H), .PAD_STEP(PAD_STEP)
    ) u_pad (
      .y_cur (pad_cur[g]),
      .go_up (buttons[2*g]),
      .go_dn (buttons[2*g+1]),
      .y_nxt (pad_nxt[g])
    );
  end

  ball_stepper #(
    .CW(CW), .SW(SW), .FRAME_H(FRAME_H), .BALL_SZ(BALL_SZ), .PAD_H(PAD_H),
    .GOAL_L(GOAL_L), .GOAL_R(GOAL_R), .SPD_MAX(SPD_MAX)
  ) u_ball (
    .bx(bx_q), .by(by_q), .dir_r(dr_q), .dir_d(dd_q), .spd(sp_q),
    .ly(ly_q), .ry(ry_q),
    .bx_nxt(bx_n), .by_nxt(by_n), .dir_r_nxt(dr_n), .dir_d_nxt(dd_n),
    .spd_nxt(sp_n), .goal(goal)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bx_q <= BX0; by_q <= BY0; dr_q <= 1'b1; dd_q <= 1'b1; sp_q <= SPD0;
      ly_q <= PY0; ry_q <= PY0; restart_q <= 1'b1;
    end else if (frame_end) begin
      if (restart_q || goal) begin
        bx_q <= BX0; by_q <= BY0; dr_q <= 1'b1; dd_q <= 1'b1; sp_q <= SPD0;
        ly_q <= PY0; ry_q <= PY0; restart_q <= 1'b0;
      end else begin
        bx_q <= bx_n; by_q <= by_n; dr_q <= dr_n; dd_q <= dd_n; sp_q <= sp_n;
        ry_q <= pad_nxt[0]; ly_q <= pad_nxt[1];
      end
    end
  end

  pixel_render #(
    .CW(CW), .BALL_SZ(BALL_SZ), .PAD_W(PAD_W), .PAD_H(PAD_H),
    .PAD_L_X(PAD_L_X), .PAD_R_X(PAD_R_X),
    .BALL_RGB(BALL_RGB), .LPAD_RGB(LPAD_RGB), .RPAD_RGB(RPAD_RGB), .BG_RGB(BG_RGB)
  ) u_render (
    .clk(clk), .rst_n(rst_n), .px(pix_x), .py(pix_y),
    .bx(bx_q), .by(by_q), .ly(ly_q), .ry(ry_q),
    .cls_q(cls), .rgb_q(pix_rgb)
  );

  assign pix_class  = cls;
  assign ball_x     = bx_q;
  assign ball_y     = by_q;
  assign ball_speed = sp_q;
  assign paddle_l_y = ly_q;
  assign paddle_r_y = ry_q;
endmodule

// File: rtl/pong_engine_chk.sv
module pong_engine_chk #(
  parameter int CW       = 12,
  parameter int SW       = 4,
  parameter int FRAME_H  = 480,
  parameter int BALL_SZ  = 8,
  parameter int PAD_W    = 8,
  parameter int PAD_H    = 64,
  parameter int PAD_STEP = 4,
  parameter int PAD_L_X  = 16,
  parameter int PAD_R_X  = 616,
  parameter int SPD_INIT = 1,
  parameter int SPD_MAX  = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    buttons,
  input logic          frame_end,
  input logic          restart,
  input logic [CW-1:0] pix_x,
  input logic [1:0]    pix_class,
  input logic [CW-1:0] ball_x,
  input logic [CW-1:0] ball_y,
  input logic [SW-1:0] ball_speed,
  input logic [CW-1:0] paddle_l_y,
  input logic [CW-1:0] paddle_r_y
);
  localparam logic [CW-1:0] PLIM  = CW'(FRAME_H - PAD_H);
  localparam logic [CW-1:0] BLIM  = CW'(FRAME_H - BALL_SZ);
  localparam logic [CW-1:0] GLC   = CW'(PAD_L_X + PAD_W);
  localparam logic [CW-1:0] GRC   = CW'(PAD_R_X - BALL_SZ);
  localparam logic [CW-1:0] STEPC = CW'(PAD_STEP);
  localparam logic [CW-1:0] PMID  = CW'((FRAME_H - PAD_H) / 2);
  localparam logic [SW-1:0] SLO   = SW'(SPD_INIT);
  localparam logic [SW-1:0] SHI   = SW'(SPD_MAX);
  localparam logic [CW:0]   BS1   = (CW+1)'(BALL_SZ);

  a_r9_hold_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(ball_x) && $stable(ball_y) && $stable(ball_speed)
                   && $stable(paddle_l_y) && $stable(paddle_r_y));

  a_r3_paddle_range: assert property (@(posedge clk) disable iff (!rst_n)
    paddle_l_y <= PLIM && paddle_r_y <= PLIM);

  a_r5_ball_rows: assert property (@(posedge clk) disable iff (!rst_n)
    ball_y <= BLIM);

  a_r8_ball_cols: assert property (@(posedge clk) disable iff (!rst_n)
    ball_x >= GLC && ball_x <= GRC);

  a_r6_speed_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    ball_speed >= SLO && ball_speed <= SHI);

  a_r2_left_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && !restart && buttons[2] && !buttons[3] && paddle_l_y >= STEPC
    |=> (paddle_l_y == $past(paddle_l_y) - STEPC) || (paddle_l_y == PMID));

  a_r10_ball_pixel: assert property (@(posedge clk) disable iff (!rst_n)
    pix_class == 2'd1 |-> ({1'b0, $past(pix_x)} >= {1'b0, $past(ball_x)})
                        && ({1'b0, $past(pix_x)} < {1'b0, $past(ball_x)} + BS1));
endmodule

bind pong_engine pong_engine_chk #(
  .CW(CW), .SW(SW), .FRAME_H(FRAME_H), .BALL_SZ(BALL_SZ), .PAD_W(PAD_W),
  .PAD_H(PAD_H), .PAD_STEP(PAD_STEP), .PAD_L_X(PAD_L_X), .PAD_R_X(PAD_R_X),
  .SPD_INIT(SPD_INIT), .SPD_MAX(SPD_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .buttons(buttons), .frame_end(frame_end),
  .restart(restart_q), .pix_x(pix_x), .pix_class(pix_class),
  .ball_x(ball_x), .ball_y(ball_y), .ball_speed(ball_speed),
  .paddle_l_y(paddle_l_y), .paddle_r_y(paddle_r_y)
);

// File: tb/pong_engine_tb_top.sv
`timescale 1ns/1ps
module pong_engine_tb_top;
  localparam int FW = 640, FH = 480, BS = 8, PW = 8, PH = 64, STEP = 4;
  localparam int LX = 16, RX = 616, SINIT = 1, SMAX = 8;
  localparam int GL = LX + PW, GR = RX - BS;
  localparam int BALL_C = 'hFFF, LPAD_C = 'h0F0, RPAD_C = 'hF80, BG_C = 'h004;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  buttons = 4'd0;
  logic        frame_end = 1'b0;
  logic [11:0] pix_x = '0, pix_y = '0;
  logic [1:0]  pix_class;
  logic [11:0] pix_rgb, ball_x, ball_y, paddle_l_y, paddle_r_y;
  logic [3:0]  ball_speed;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  pong_engine dut_i (
    .clk(clk), .rst_n(rst_n), .buttons(buttons), .frame_end(frame_end),
    .pix_x(pix_x), .pix_y(pix_y), .pix_class(pix_class), .pix_rgb(pix_rgb),
    .ball_x(ball_x), .ball_y(ball_y), .ball_speed(ball_speed),
    .paddle_l_y(paddle_l_y), .paddle_r_y(paddle_r_y)
  );

  // behavioural reference state
  int m_bx, m_by, m_dr, m_dd, m_sp, m_ly, m_ry, m_rst;
  int e_cls, e_rgb;
  int goals = 0, bounces = 0;

  task automatic centre();
    m_bx = (FW - BS) / 2; m_by = (FH - BS) / 2; m_dr = 1; m_dd = 1;
    m_sp = SINIT; m_ly = (FH - PH) / 2; m_ry = (FH - PH) / 2;
  endtask

  function automatic int pad_move(int y, bit up, bit dn);
    if (up && !dn && y >= STEP) return y - STEP;
    if (dn && !up && y + STEP <= FH - PH) return y + STEP;
    return y;
  endfunction

  function automatic bit inside_box(int px, int py, int ox, int oy, int w, int h);
    return px >= ox && px < ox + w && py >= oy && py < oy + h;
  endfunction

  task automatic model_frame();
    int nbx, nby, ndr, ndd, nsp, nly, nry;
    bit g, meet;
    nly = pad_move(m_ly, buttons[2], buttons[3]);
    nry = pad_move(m_ry, buttons[0], buttons[1]);
    nby = m_by; ndd = m_dd;
    if (!m_dd && m_by == 0) ndd = 1;
    else if (m_dd && m_by == FH - BS) ndd = 0;
    else if (m_dd) nby = (m_by + m_sp > FH - BS) ? FH - BS : m_by + m_sp;
    else nby = (m_by - m_sp < 0) ? 0 : m_by - m_sp;
    nbx = m_bx; ndr = m_dr; nsp = m_sp; g = 0;
    if ((!m_dr && m_bx == GL) || (m_dr && m_bx == GR)) begin
      meet = m_dr ? (m_by < m_ry + PH && m_by + BS > m_ry)
                  : (m_by < m_ly + PH && m_by + BS > m_ly);
      if (meet) begin
        ndr = m_dr ? 0 : 1; nsp = (m_sp >= SMAX) ? SMAX : m_sp + 1; bounces++;
      end else g = 1;
    end else if (m_dr) nbx = (m_bx + m_sp > GR) ? GR : m_bx + m_sp;
    else nbx = (m_bx - m_sp < GL) ? GL : m_bx - m_sp;
    if (g) begin centre(); goals++; end
    else begin
      m_bx = nbx; m_by = nby; m_dr = ndr; m_dd = ndd; m_sp = nsp; m_ly = nly; m_ry = nry;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      centre(); m_rst = 1; e_cls = 0; e_rgb = BG_C;
    end else begin
      if (inside_box(pix_x, pix_y, m_bx, m_by, BS, BS))      begin e_cls = 1; e_rgb = BALL_C; end
      else if (inside_box(pix_x, pix_y, LX, m_ly, PW, PH))  begin e_cls = 2; e_rgb = LPAD_C; end
      else if (inside_box(pix_x, pix_y, RX, m_ry, PW, PH))  begin e_cls = 3; e_rgb = RPAD_C; end
      else                                                 begin e_cls = 0; e_rgb = BG_C; end
      if (frame_end) begin
        if (m_rst) begin m_rst = 0; centre(); end
        else model_frame();
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("R8 R6 R7 ball_x", ball_x, m_bx);
      check("R4 R5 R9 ball_y", ball_y, m_by);
      check("R6 ball_speed", ball_speed, m_sp);
      check("R1 R2 R3 paddle_l_y", paddle_l_y, m_ly);
      check("R1 R2 R3 paddle_r_y", paddle_r_y, m_ry);
      check("R10 pix_class", pix_class, e_cls);
      check("R11 pix_rgb", pix_rgb, e_rgb);
    end
  end

  task automatic drive_pix();
    int sel, x, y;
    sel = $urandom_range(0, 3);
    case (sel)
      0: begin x = m_bx - 2 + $urandom_range(0, 11); y = m_by - 2 + $urandom_range(0, 11); end
      1: begin x = LX - 2 + $urandom_range(0, 11); y = m_ly - 2 + $urandom_range(0, 67); end
      2: begin x = RX - 2 + $urandom_range(0, 11); y = m_ry - 2 + $urandom_range(0, 67); end
      default: begin x = $urandom_range(0, FW - 1); y = $urandom_range(0, FH - 1); end
    endcase
    if (x < 0) x = 0;
    if (y < 0) y = 0;
    pix_x = 12'(x); pix_y = 12'(y);
  endtask

  function automatic logic [3:0] pick(int mode);
    logic [3:0] b = 4'd0;
    if (mode == 0) begin
      if (m_ry + PH / 2 > m_by + BS / 2 + 2) b[0] = 1'b1;
      else if (m_ry + PH / 2 < m_by + BS / 2 - 2) b[1] = 1'b1;
      if (m_ly + PH / 2 > m_by + BS / 2 + 2) b[2] = 1'b1;
      else if (m_ly + PH / 2 < m_by + BS / 2 - 2) b[3] = 1'b1;
    end else if (mode == 1) b = 4'($urandom_range(0, 15));
    return b;
  endfunction

  task automatic run_frame(int mode);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      drive_pix();
      frame_end = (k == 2);
      if (k == 2) buttons = pick(mode);
      else buttons = 4'($urandom_range(0, 15)); // R9: ignored without frame_end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9: reset gives the centred start
    check("R9 reset ball_x", ball_x, (FW - BS) / 2);
    check("R9 reset ball_y", ball_y, (FH - BS) / 2);
    check("R9 reset speed", ball_speed, SINIT);
    check("R9 reset paddle_l_y", paddle_l_y, (FH - PH) / 2);
    check("R9 reset paddle_r_y", paddle_r_y, (FH - PH) / 2);
    check("R10 reset class", pix_class, 0);
    run_frame(1);
    for (int f = 0; f < 2500; f++) run_frame(0);
    for (int f = 0; f < 800; f++) run_frame(1);
    for (int f = 0; f < 1200; f++) run_frame(2);
    @(negedge clk);
    frame_end = 1'b0;
    repeat (3) @(negedge clk);
    // R6 R7: both a paddle bounce and a goal restart were reached
    checks++;
    if (bounces == 0 || goals == 0) begin
      errors++;
      $display("FAIL R6 R7 bounces=%0d goals=%0d expected both nonzero", bounces, goals);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule